// File: doc/BRIEF.md
# IDE Controller Configuration Register Bank

This block holds the configuration state of a two-channel IDE controller. Software reaches it through three byte-wide I/O addresses. A key address holds a byte that must match an unlock value before any configuration register can be changed. A select address chooses one of the internal registers, and a window address reads or writes the selected register. The registers store drive timing counts, buffer-mode bits, port-enable bits and sector byte-count fields. Each register keeps only its own set of writable bits.

The block turns two of its stored bits into channel enable outputs. The first channel is enabled by bit 0 of the general configuration register at index 0x01. The second channel is enabled only when the first is enabled and the disable bit (bit 6) of the register at index 0x35 is clear. Read data depends only on the presented address. There is no read strobe, so a host can sample the read data in the same cycle it drives the address.

Top module: `ide_cfg_regs`

## Requirements
- R1: A write to address 0x00F4 stores the full byte as the key. A read of 0x00F4 returns the stored key.
- R2: A write to address 0x00F8 stores the register select whether or not the bank is unlocked. A later access to address 0x00FC reaches the register at that select value.
- R3: A write to 0x00FC changes no register unless the key equals 0x30. A key of any other value, including 0x31 and 0x00, leaves the register contents as they were.
- R4: The stored value is the written byte ANDed with the register's mask. Index 0x01 keeps mask 0x8F, index 0x09 keeps 0xC3 and index 0x0A keeps 0x4F. Indexes 0x07 and 0x35 keep all eight bits.
- R5: The drive timing counts at indexes 0x02 to 0x06 and 0x25 to 0x33 keep only bits 4:0 (mask 0x1F).
- R6: The sector byte-count low parts at indexes 0x0B, 0x0D, 0x0F and 0x11 keep mask 0x03. The high parts at 0x0C, 0x0E, 0x10 and 0x12 keep mask 0x1F.
- R7: A write to any index outside the writable set has no effect, even when the bank is unlocked. This covers 0x00, 0x08, 0x13, 0x24, 0x34 and 0xFF.
- R8: After reset the registers read 0x57 at index 0x00 and 0x02 at 0x01. Indexes 0x08 and 0x34 read 0xFF, and 0x09 reads 0x41. Indexes 0x0C, 0x0E, 0x10 and 0x12 read 0x02, and 0x35 reads 0x01. Every other index reads 0x00.
- R9: The primary enable output equals bit 0 of index 0x01. The secondary enable output is high only when that bit is 1 and bit 6 of index 0x35 is 0. Both outputs change one clock edge after the register that feeds them changes.
- R10: A read of 0x00FC returns the register at the current select, with or without the key. A read of 0x00F8 or of any address other than 0x00F4 and 0x00FC returns 0xFF.
- R11: The key resets to 0x00, so the bank is locked after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the presented address (combinational) |
| pri_chan_en | output | 1 | Primary channel enable |
| sec_chan_en | output | 1 | Secondary channel enable |

## Verification
Read data is combinational, so it is due in the same cycle the address is presented. A write takes effect at the edge that samples it. Its result is therefore visible on the read port from that edge onward, and the channel enables follow one edge later. The bench changes inputs just after a rising edge and samples every output at the falling edge. There it compares against a behavioural model that applies writes at the same edge and lags the enables by one edge. Directed checks also sample the enables immediately after the writing edge, to confirm they have not yet moved, and again one edge later.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KEY  = 2'd1,
      SEL_IDX  = 2'd2,
      SEL_WIN  = 2'd3
   } port_sel_e;

   // Writable-bit mask for each register index; zero marks a read-only slot
   function automatic logic [BYTE_W-1:0] cfg_wmask(input int unsigned i);
      if ((i >= 32'h02 && i <= 32'h06) || (i >= 32'h25 && i <= 32'h33))
         return 8'h1F;
      case (i)
         32'h01:                         return 8'h8F;
         32'h07, 32'h35:                 return 8'hFF;
         32'h09:                         return 8'hC3;
         32'h0A:                         return 8'h4F;
         32'h0B, 32'h0D, 32'h0F, 32'h11: return 8'h03;
         32'h0C, 32'h0E, 32'h10, 32'h12: return 8'h1F;
         default:                        return 8'h00;
      endcase
   endfunction

   // Power-on contents of each register index
   function automatic logic [BYTE_W-1:0] cfg_rstval(input int unsigned i);
      case (i)
         32'h00:                         return 8'h57;
         32'h01:                         return 8'h02;
         32'h08, 32'h34:                 return 8'hFF;
         32'h09:                         return 8'h41;
         32'h0C, 32'h0E, 32'h10, 32'h12: return 8'h02;
         32'h35:                         return 8'h01;
         default:                        return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ide_cfg_decode.sv
module ide_cfg_decode
   import ide_cfg_pkg::*;
#(
   parameter int unsigned     ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h00F4,
   parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h00F8,
   parameter logic [ADDR_W-1:0] WIN_ADDR = 16'h00FC
) (
   input  logic [ADDR_W-1:0] addr,
   output port_sel_e         sel
);

   always_comb begin
      if (addr == KEY_ADDR)      sel = SEL_KEY;
      else if (addr == IDX_ADDR) sel = SEL_IDX;
      else if (addr == WIN_ADDR) sel = SEL_WIN;
      else                       sel = SEL_NONE;
   end

endmodule

// File: rtl/ide_cfg_regbank.sv
module ide_cfg_regbank
   import ide_cfg_pkg::*;
#(
   parameter int unsigned NUM_REGS = 256,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_data,
   output logic              pri_bit,
   output logic              sec_dis_bit
);

   localparam int unsigned GEN_IDX = 32'h01;
   localparam int unsigned PEN_IDX = 32'h35;

   logic [NUM_REGS-1:0][BYTE_W-1:0] bank;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [BYTE_W-1:0] MASK = cfg_wmask(i);
      localparam logic [BYTE_W-1:0] RVAL = cfg_rstval(i);
      if (MASK == '0) begin : g_fixed
         assign bank[i] = RVAL;
      end else begin : g_store
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RVAL;
            else if (wr_en && (wr_idx == IDX_W'(i)))
               q <= wr_data & MASK;
         end
         assign bank[i] = q;
      end
   end

   assign rd_data     = bank[rd_idx];
   assign pri_bit     = bank[GEN_IDX][0];
   assign sec_dis_bit = bank[PEN_IDX][6];

endmodule

// File: rtl/ide_cfg_chan_en.sv
module ide_cfg_chan_en #(
   parameter bit EN_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_bit,
   input  logic sec_dis_bit,
   output logic pri_en,
   output logic sec_en
);

   logic pri_d, sec_d;

   always_comb begin
      pri_d = pri_bit;
      sec_d = pri_bit & ~sec_dis_bit;
   end

   if (EN_REGISTERED) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pri_en <= 1'b0;
            sec_en <= 1'b0;
         end else begin
            pri_en <= pri_d;
            sec_en <= sec_d;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pri_en = pri_d;
      assign sec_en = sec_d;
   end

endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
   import ide_cfg_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR      = 16'h00F4,
   parameter logic [ADDR_W-1:0] IDX_ADDR      = 16'h00F8,
   parameter logic [ADDR_W-1:0] WIN_ADDR      = 16'h00FC,
   parameter logic [7:0]        UNLOCK_KEY    = 8'h30,
   parameter int unsigned       NUM_REGS      = 256,
   parameter bit                EN_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              pri_chan_en,
   output logic              sec_chan_en
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (IDX_W > BYTE_W) begin : g_chk_wide
      $error("NUM_REGS exceeds the range of a byte-wide select");
   end
   if (NUM_REGS != (1 << IDX_W)) begin : g_chk_pow2
      $error("NUM_REGS must be a power of two");
   end
   if (NUM_REGS <= 32'h35) begin : g_chk_small
      $error("NUM_REGS too small for the port-enable register");
   end
   if ((KEY_ADDR == IDX_ADDR) || (KEY_ADDR == WIN_ADDR) || (IDX_ADDR == WIN_ADDR)) begin : g_chk_addr
      $error("port addresses must be distinct");
   end

   port_sel_e         sel;
   logic [7:0]        key_q;
   logic [IDX_W-1:0]  idx_q;
   logic              unlocked;
   logic              bank_wr;
   logic [7:0]        bank_rd;
   logic              cfg_pri_bit;
   logic              cfg_sec_dis;

   ide_cfg_decode #(
      .ADDR_W   (ADDR_W),
      .KEY_ADDR (KEY_ADDR),
      .IDX_ADDR (IDX_ADDR),
      .WIN_ADDR (WIN_ADDR)
   ) u_dec (
      .addr (io_addr),
      .sel  (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         idx_q <= '0;
      end else if (io_wr) begin
         if (sel == SEL_KEY) key_q <= io_wdata;
         if (sel == SEL_IDX) idx_q <= io_wdata[IDX_W-1:0];
      end
   end

   assign unlocked = (key_q == UNLOCK_KEY);
   assign bank_wr  = io_wr && (sel == SEL_WIN) && unlocked;

   ide_cfg_regbank #(
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bank_wr),
      .wr_idx      (idx_q),
      .wr_data     (io_wdata),
      .rd_idx      (idx_q),
      .rd_data     (bank_rd),
      .pri_bit     (cfg_pri_bit),
      .sec_dis_bit (cfg_sec_dis)
   );

   ide_cfg_chan_en #(
      .EN_REGISTERED (EN_REGISTERED)
   ) u_en (
      .clk         (clk),
      .rst_n       (rst_n),
      .pri_bit     (cfg_pri_bit),
      .sec_dis_bit (cfg_sec_dis),
      .pri_en      (pri_chan_en),
      .sec_en      (sec_chan_en)
   );

   always_comb begin
      case (sel)
         SEL_KEY: io_rdata = key_q;
         SEL_WIN: io_rdata = bank_rd;
         default: io_rdata = 8'hFF;
      endcase
   end

endmodule

// File: rtl/ide_cfg_chk.sv
module ide_cfg_chk #(
   parameter int unsigned       ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR      = 16'h00F4,
   parameter logic [ADDR_W-1:0] WIN_ADDR      = 16'h00FC,
   parameter logic [7:0]        UNLOCK_KEY    = 8'h30,
   parameter int unsigned       IDX_W         = 8,
   parameter bit                EN_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              pri_chan_en,
   input logic              sec_chan_en,
   input logic [7:0]        key_q,
   input logic [IDX_W-1:0]  idx_q,
   input logic              cfg_pri_bit
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R9: secondary channel never runs without the primary
   a_r9_sec_needs_pri: assert property (@(posedge clk) disable iff (!rst_n)
      sec_chan_en |-> pri_chan_en);

   if (EN_REGISTERED) begin : g_lag
      // R9: primary enable follows its config bit one edge later
      a_r9_pri_lag: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (pri_chan_en == $past(cfg_pri_bit)));
   end else begin : g_now
      // R9: primary enable tracks its config bit directly
      a_r9_pri_now: assert property (@(posedge clk) disable iff (!rst_n)
         pri_chan_en == cfg_pri_bit);
   end

   // R10: addresses outside the key and window ports read all ones
   a_r10_other_ff: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_addr != KEY_ADDR) && (io_addr != WIN_ADDR)) |-> (io_rdata == 8'hFF));

   // R1: key byte reads back what was written
   a_r1_key_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(io_wr) && ($past(io_addr) == KEY_ADDR) && (io_addr == KEY_ADDR))
      |-> (io_rdata == $past(io_wdata)));

   // R3: a locked window write leaves the selected register unchanged
   a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(io_wr) && ($past(io_addr) == WIN_ADDR) && ($past(key_q) != UNLOCK_KEY)
       && (io_addr == WIN_ADDR) && $stable(idx_q))
      |-> (io_rdata == $past(io_rdata)));

endmodule

bind ide_cfg_regs ide_cfg_chk #(
   .ADDR_W        (ADDR_W),
   .KEY_ADDR      (KEY_ADDR),
   .WIN_ADDR      (WIN_ADDR),
   .UNLOCK_KEY    (UNLOCK_KEY),
   .IDX_W         (IDX_W),
   .EN_REGISTERED (EN_REGISTERED)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_addr     (io_addr),
   .io_wr       (io_wr),
   .io_wdata    (io_wdata),
   .io_rdata    (io_rdata),
   .pri_chan_en (pri_chan_en),
   .sec_chan_en (sec_chan_en),
   .key_q       (key_q),
   .idx_q       (idx_q),
   .cfg_pri_bit (cfg_pri_bit)
);

// File: tb/ide_cfg_regs_tb.sv
`timescale 1ns/1ps
module ide_cfg_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        pri_chan_en, sec_chan_en;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   ide_cfg_regs u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_addr     (io_addr),
      .io_wr       (io_wr),
      .io_wdata    (io_wdata),
      .io_rdata    (io_rdata),
      .pri_chan_en (pri_chan_en),
      .sec_chan_en (sec_chan_en)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_mask [256];
   logic [7:0] m_reg  [256];
   logic [7:0] m_key;
   logic [7:0] m_idx;
   logic       m_pri, m_sec;

   initial begin
      for (int i = 0; i < 256; i++) m_mask[i] = 8'h00;
      for (int i = 8'h02; i <= 8'h06; i++) m_mask[i] = 8'h1F;
      for (int i = 8'h25; i <= 8'h33; i++) m_mask[i] = 8'h1F;
      m_mask[8'h01] = 8'h8F; m_mask[8'h07] = 8'hFF; m_mask[8'h09] = 8'hC3;
      m_mask[8'h0A] = 8'h4F; m_mask[8'h35] = 8'hFF;
      m_mask[8'h0B] = 8'h03; m_mask[8'h0D] = 8'h03; m_mask[8'h0F] = 8'h03; m_mask[8'h11] = 8'h03;
      m_mask[8'h0C] = 8'h1F; m_mask[8'h0E] = 8'h1F; m_mask[8'h10] = 8'h1F; m_mask[8'h12] = 8'h1F;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) m_reg[i] <= 8'h00;
         m_reg[8'h00] <= 8'h57; m_reg[8'h01] <= 8'h02; m_reg[8'h08] <= 8'hFF;
         m_reg[8'h09] <= 8'h41; m_reg[8'h0C] <= 8'h02; m_reg[8'h0E] <= 8'h02;
         m_reg[8'h10] <= 8'h02; m_reg[8'h12] <= 8'h02; m_reg[8'h34] <= 8'hFF;
         m_reg[8'h35] <= 8'h01;
         m_key <= 8'h00; m_idx <= 8'h00; m_pri <= 1'b0; m_sec <= 1'b0;
      end else begin
         m_pri <= m_reg[8'h01][0];
         m_sec <= m_reg[8'h01][0] && !m_reg[8'h35][6];
         if (io_wr) begin
            if (io_addr == 16'h00F4) m_key <= io_wdata;
            if (io_addr == 16'h00F8) m_idx <= io_wdata;
            if (io_addr == 16'h00FC && m_key == 8'h30 && m_mask[m_idx] != 8'h00)
               m_reg[m_idx] <= io_wdata & m_mask[m_idx];
         end
      end
   end

   function automatic logic [7:0] model_rd(input logic [15:0] a);
      if (a == 16'h00F4) return m_key;
      if (a == 16'h00FC) return m_reg[m_idx];
      return 8'hFF;
   endfunction

   always @(negedge clk) begin
      if (rst_n && cmp_on && !finished) begin
         n_chk++;
         if (io_rdata !== model_rd(io_addr)) begin
            n_fail++;
            $display("FAIL R10 model read at addr %h: actual %h expected %h", io_addr, io_rdata, model_rd(io_addr));
         end
         n_chk++;
         if (pri_chan_en !== m_pri || sec_chan_en !== m_sec) begin
            n_fail++;
            $display("FAIL R9 model enables: actual %b%b expected %b%b", pri_chan_en, sec_chan_en, m_pri, m_sec);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk); #1;
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      io_addr = a;
      @(negedge clk);
      d = io_rdata;
   endtask

   task automatic rd_reg(input logic [7:0] idx, input string tag, input logic [7:0] exp);
      logic [7:0] v;
      wr(16'h00F8, idx);
      rd(16'h00FC, v);
      check(tag, v, exp);
   endtask

   task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
      wr(16'h00F8, idx);
      wr(16'h00FC, d);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;

      // R11 and R8: reset state
      rd(16'h00F4, v); check("R11 key after reset", v, 8'h00);
      check("R9 pri after reset", {7'd0, pri_chan_en}, 8'h00);
      check("R9 sec after reset", {7'd0, sec_chan_en}, 8'h00);
      rd_reg(8'h00, "R8 idx00", 8'h57);
      rd_reg(8'h01, "R8 idx01", 8'h02);
      rd_reg(8'h08, "R8 idx08", 8'hFF);
      rd_reg(8'h09, "R8 idx09", 8'h41);
      rd_reg(8'h0C, "R8 idx0C", 8'h02);
      rd_reg(8'h12, "R8 idx12", 8'h02);
      rd_reg(8'h34, "R8 idx34", 8'hFF);
      rd_reg(8'h35, "R8 idx35", 8'h01);
      rd_reg(8'h20, "R8 idx20", 8'h00);

      // R3: locked writes, R2 select works while locked
      wr_reg(8'h07, 8'hAA);
      rd(16'h00FC, v); check("R3 locked key 00", v, 8'h00);
      wr(16'h00F4, 8'h31);
      rd(16'h00F4, v); check("R1 key readback 31", v, 8'h31);
      wr_reg(8'h07, 8'h5A);
      rd(16'h00FC, v); check("R3 locked key 31", v, 8'h00);

      // unlock
      wr(16'h00F4, 8'h30);
      rd(16'h00F4, v); check("R1 key readback 30", v, 8'h30);
      wr_reg(8'h07, 8'hA5);
      rd(16'h00FC, v); check("R2 R4 idx07 full", v, 8'hA5);

      // R9 timing: enables lag the register by one edge
      wr(16'h00F8, 8'h01);
      wr(16'h00FC, 8'hFF);
      check("R9 pri not yet", {7'd0, pri_chan_en}, 8'h00);
      @(posedge clk); #1;
      check("R9 pri one edge later", {7'd0, pri_chan_en}, 8'h01);
      check("R9 sec one edge later", {7'd0, sec_chan_en}, 8'h01);
      rd(16'h00FC, v); check("R4 idx01 mask", v, 8'h8F);

      rd_reg(8'h09, "R4 idx09 before", 8'h41);
      wr(16'h00FC, 8'hFF); rd(16'h00FC, v); check("R4 idx09 mask", v, 8'hC3);
      wr_reg(8'h0A, 8'hFF); rd(16'h00FC, v); check("R4 idx0A mask", v, 8'h4F);
      wr_reg(8'h35, 8'hFF); rd(16'h00FC, v); check("R4 idx35 full", v, 8'hFF);
      @(posedge clk); #1;
      check("R9 sec disabled by bit6", {7'd0, sec_chan_en}, 8'h00);
      check("R9 pri stays", {7'd0, pri_chan_en}, 8'h01);
      wr(16'h00FC, 8'hBF);
      @(posedge clk); #1;
      check("R9 sec back on", {7'd0, sec_chan_en}, 8'h01);
      wr_reg(8'h01, 8'h0E);
      @(posedge clk); #1;
      check("R9 pri off", {7'd0, pri_chan_en}, 8'h00);
      check("R9 sec off with pri", {7'd0, sec_chan_en}, 8'h00);

      // R5: timing counts
      wr_reg(8'h02, 8'hFF); rd(16'h00FC, v); check("R5 idx02", v, 8'h1F);
      wr_reg(8'h06, 8'hE3); rd(16'h00FC, v); check("R5 idx06", v, 8'h03);
      wr_reg(8'h29, 8'hFF); rd(16'h00FC, v); check("R5 idx29", v, 8'h1F);
      wr_reg(8'h2A, 8'hF5); rd(16'h00FC, v); check("R5 idx2A", v, 8'h15);
      wr_reg(8'h33, 8'hE7); rd(16'h00FC, v); check("R5 idx33", v, 8'h07);

      // R6: sector byte counts
      wr_reg(8'h0B, 8'hFF); rd(16'h00FC, v); check("R6 idx0B", v, 8'h03);
      wr_reg(8'h11, 8'hFE); rd(16'h00FC, v); check("R6 idx11", v, 8'h02);
      wr_reg(8'h0C, 8'hFF); rd(16'h00FC, v); check("R6 idx0C", v, 8'h1F);
      wr_reg(8'h12, 8'hE8); rd(16'h00FC, v); check("R6 idx12", v, 8'h08);

      // R7: read-only and unimplemented indexes
      wr_reg(8'h00, 8'hFF); rd(16'h00FC, v); check("R7 idx00", v, 8'h57);
      wr_reg(8'h08, 8'h00); rd(16'h00FC, v); check("R7 idx08", v, 8'hFF);
      wr_reg(8'h34, 8'h00); rd(16'h00FC, v); check("R7 idx34", v, 8'hFF);
      wr_reg(8'h13, 8'hFF); rd(16'h00FC, v); check("R7 idx13", v, 8'h00);
      wr_reg(8'h24, 8'hFF); rd(16'h00FC, v); check("R7 idx24", v, 8'h00);
      wr_reg(8'hFF, 8'h12); rd(16'h00FC, v); check("R7 idxFF", v, 8'h00);

      // R10: other ports, window read while locked
      rd(16'h00F8, v); check("R10 index port reads FF", v, 8'hFF);
      rd(16'h0000, v); check("R10 addr 0000", v, 8'hFF);
      rd(16'h01F4, v); check("R10 addr 01F4", v, 8'hFF);
      wr(16'h00F4, 8'h00);
      wr(16'h00F8, 8'h07);
      rd(16'h00FC, v); check("R10 locked window read", v, 8'hA5);
      wr(16'h00FC, 8'h11);
      rd(16'h00FC, v); check("R3 relocked write ignored", v, 8'hA5);

      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule